// File: doc/BRIEF.md
# Slot-Interleaved Video RAM Arbiter

This block owns a single-port byte-wide video RAM and shares it between two users: a playout path that scans the memory one byte per pixel, and a host that updates the memory. Main-clock cycles alternate between a pixel slot and a RAM-access slot. In a pixel slot the block reads the byte at the current scan address. In a RAM-access slot it writes one byte taken from a small internal FIFO to the RAM, or it leaves the RAM idle when the FIFO holds nothing. Because each cycle belongs to exactly one user, a pixel read and a host write can never collide.

The host does not give an address with each byte. It loads a start address once through a preset command, then streams bytes over a valid/ready interface. Each byte committed to RAM advances the write address by one. A preset applies to every byte that has not yet been committed. A host that needs a byte at an exact address should let the FIFO drain before it presets again. The host data interface follows the usual back-pressure rule: a byte transfers on a rising edge where `host_valid` and `host_ready` are both high. `host_ready` falls while the FIFO is full. A byte offered while `host_ready` is low is not taken, and the host may change it freely until it is taken. The playout side has no back-pressure. Each `pix_valid` pulse carries one byte and its address.

Top module: `vram_slot_arbiter`

## Requirements
- R1: After reset, `pix_stb` is high and `ram_stb` is low. The two strobes are always complements of each other, and each one toggles on every clock, so each strobe runs at half the clock rate.
- R2: `pix_valid` is high exactly in the cycle after each pixel slot, which is every cycle where `ram_stb` is high. Successive pulses carry `pix_addr` values 0, 1, 2 and so on, which wrap modulo 2^ADDR_W.
- R3: The `pix_data` that comes with a `pix_valid` pulse equals the last byte committed to address `pix_addr` before that pixel slot.
- R4: A RAM write happens only in a RAM-access slot, and at most one byte is written per slot. When the FIFO is empty the slot leaves the RAM untouched.
- R5: The FIFO holds 16 bytes. `host_ready` is high after reset and is low exactly while 16 bytes are held. A byte offered while `host_ready` is low is not stored.
- R6: After a preset with address A, the next committed bytes land at A, A+1, A+2 and so on, which wrap modulo 2^ADDR_W.
- R7: When a preset occurs in the same cycle as a commit, that committed byte still goes to the old address. The preset applies starting with the following commit.
- R8: Accepted bytes are committed in the order they were accepted, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | FIFO can accept a byte |
| host_data | input | DATA_W | Byte to be written |
| preset_en | input | 1 | Load the write-address counter |
| preset_addr | input | ADDR_W | Value loaded on preset |
| pix_stb | output | 1 | High during a pixel slot |
| ram_stb | output | 1 | High during a RAM-access slot |
| pix_valid | output | 1 | Pixel byte output is valid |
| pix_addr | output | ADDR_W | Address the pixel byte was read from |
| pix_data | output | DATA_W | Pixel byte |

## Verification
A fault in the write-address counter or the FIFO pointers shows up as wrong bytes during playout. After the FIFO drains, one full scan (2^ADDR_W pixel pulses, twice that many clocks) shows every corrupted, shifted or missing byte. A wrong slot phase shows at once on the strobes and on `pix_valid` alignment. A wrong full count shows as `host_ready` staying high when it should be low, or as a junk byte that should have been ignored appearing in memory.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic {SLOT_PIX = 1'b0, SLOT_RAM = 1'b1} slot_t;
endpackage

// File: rtl/vram_slot_gen.sv
module vram_slot_gen
  import vram_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= SLOT_PIX;
    else        slot <= (slot == SLOT_PIX) ? SLOT_RAM : SLOT_PIX;
  end

  assert_slot_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_PIX) |=> (slot == SLOT_RAM));
  assert_slot_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_RAM) |=> (slot == SLOT_PIX));
endmodule

// File: rtl/vram_wr_fifo.sv
module vram_wr_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     count;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign rd_data = store[rp];

  always_ff @(posedge clk) begin
    if (wr_en) store[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> !wr_en);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));
endmodule

// File: rtl/vram_wr_addr_ctr.sv
module vram_wr_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_en,
  input  logic [ADDR_W-1:0] preset_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (preset_en) addr <= preset_addr;
    else if (advance)   addr <= addr + 1'b1;
  end

  assert_preset_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preset_en |=> (addr == $past(preset_addr)));
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !preset_en) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/vram_sp_ram.sv
module vram_sp_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_comb begin
    assert_single_port_R4: assert (!(we && re));
  end
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [DATA_W-1:0] host_data,
  input  logic              preset_en,
  input  logic [ADDR_W-1:0] preset_addr,
  output logic              pix_stb,
  output logic              ram_stb,
  output logic              pix_valid,
  output logic [ADDR_W-1:0] pix_addr,
  output logic [DATA_W-1:0] pix_data
);
  slot_t             slot;
  logic              fifo_full, fifo_empty, push, commit;
  logic [DATA_W-1:0] head;
  logic [ADDR_W-1:0] wr_addr, scan_addr, ram_addr;
  logic              pix_slot, ram_slot;

  vram_slot_gen u_slot (.clk(clk), .rst_n(rst_n), .slot(slot));

  assign pix_slot = (slot == SLOT_PIX);
  assign ram_slot = (slot == SLOT_RAM);
  assign pix_stb  = pix_slot;
  assign ram_stb  = ram_slot;

  assign host_ready = !fifo_full;
  assign push       = host_valid && !fifo_full;
  assign commit     = ram_slot && !fifo_empty;

  vram_wr_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(host_data),
    .rd_en(commit), .rd_data(head), .full(fifo_full), .empty(fifo_empty)
  );

  vram_wr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .preset_en(preset_en), .preset_addr(preset_addr),
    .advance(commit), .addr(wr_addr)
  );

  assign ram_addr = ram_slot ? wr_addr : scan_addr;

  vram_sp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(commit), .re(pix_slot), .addr(ram_addr),
    .wdata(head), .rdata(pix_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_addr <= '0;
      pix_addr  <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= pix_slot;
      if (pix_slot) begin
        pix_addr  <= scan_addr;
        scan_addr <= scan_addr + 1'b1;
      end
    end
  end

  assert_write_in_ram_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ram_stb);
  assert_valid_after_pix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> pix_valid);
  assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid, 2)) |-> (pix_addr == ADDR_W'($past(pix_addr, 2) + 1'b1)));
endmodule

// File: tb/vram_slot_arbiter_bench.sv
module vram_slot_arbiter_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_valid = 1'b0;
  logic          host_ready;
  logic [DW-1:0] host_data = '0;
  logic          preset_en = 1'b0;
  logic [AW-1:0] preset_addr = '0;
  logic          pix_stb, ram_stb, pix_valid;
  logic [AW-1:0] pix_addr;
  logic [DW-1:0] pix_data;

  int tests = 0;
  int fails = 0;
  int full_seen = 0;
  logic [DW-1:0] model [WORDS];
  logic [AW-1:0] model_ptr = '0;

  always #10 clk = ~clk;

  vram_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(16)) u_vram_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_data(host_data), .preset_en(preset_en), .preset_addr(preset_addr),
    .pix_stb(pix_stb), .ram_stb(ram_stb), .pix_valid(pix_valid),
    .pix_addr(pix_addr), .pix_data(pix_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the negedge after the byte is taken
  task automatic push(input logic [DW-1:0] b);
    host_valid = 1'b1;
    forever begin
      if (host_ready) begin
        host_data = b;
        @(negedge clk);
        break;
      end
      host_data = b ^ 8'h5A;  // junk while not ready, must be ignored (R5)
      full_seen++;
      @(negedge clk);
    end
    host_valid = 1'b0;
    model[model_ptr] = b;
    model_ptr = model_ptr + 1'b1;
  endtask

  task automatic preset(input logic [AW-1:0] a);
    preset_en = 1'b1;
    preset_addr = a;
    @(negedge clk);
    preset_en = 1'b0;
    model_ptr = a;
  endtask

  task automatic drain();
    for (int i = 0; i < 48; i++) @(negedge clk);
  endtask

  task automatic check_slots(input int n);
    for (int i = 0; i < n; i++) begin
      logic prev;
      prev = pix_stb;
      check("R1 strobes complementary", {31'd0, pix_stb ^ ram_stb}, 32'd1);
      check("R2 pix_valid aligned", {31'd0, pix_valid}, {31'd0, ram_stb});
      @(negedge clk);
      check("R1 strobe toggles", {31'd0, pix_stb}, {31'd0, ~prev});
    end
  endtask

  task automatic scan(input string tag);
    logic [AW-1:0] last;
    for (int k = 0; k < WORDS; k++) begin
      do @(negedge clk); while (!pix_valid);
      if (k > 0) check("R2 scan address step", {24'd0, pix_addr}, {24'd0, AW'(last + 1'b1)});
      last = pix_addr;
      check(tag, {24'd0, pix_data}, {24'd0, model[pix_addr]});
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a_old;
    repeat (3) @(negedge clk);
    // reset state (R1, R2, R5)
    check("R1 reset pix_stb", {31'd0, pix_stb}, 32'd1);
    check("R1 reset ram_stb", {31'd0, ram_stb}, 32'd0);
    check("R2 reset pix_valid", {31'd0, pix_valid}, 32'd0);
    check("R5 reset host_ready", {31'd0, host_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_slots(20);

    // fill the whole RAM in one back-to-back stream (R3, R4, R5, R6, R8)
    preset('0);
    for (int i = 0; i < WORDS; i++) push(DW'(i * 37 + 5));
    check("R5 back-pressure seen", {31'd0, full_seen > 0}, 32'd1);
    drain();
    check("R5 ready after drain", {31'd0, host_ready}, 32'd1);
    scan("R3 R8 full fill");

    // preset near the top, wrap past the end (R6)
    preset(AW'(WORDS - 6));
    for (int i = 0; i < 12; i++) push(DW'(8'hC0 + i));
    drain();
    scan("R6 wrap");

    // idle slots leave memory untouched (R4)
    for (int i = 0; i < 64; i++) @(negedge clk);
    scan("R4 idle slots");

    // preset in the same cycle as a commit (R7)
    preset(AW'(100));
    drain();
    a_old = model_ptr;
    while (!ram_stb) @(negedge clk);
    host_valid = 1'b1; host_data = 8'hA7;
    @(negedge clk);
    host_valid = 1'b0;
    model[a_old] = 8'hA7;
    @(negedge clk);                       // commit slot of 8'hA7
    check("R7 commit slot", {31'd0, ram_stb}, 32'd1);
    preset(AW'(200));
    push(8'h3C);
    drain();
    scan("R7 preset during commit");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule